// File: doc/BRIEF.md
# Clock-Slave Stereo Serial Sample Transmitter

This block sends a stereo pair of 16-bit two's complement samples as one serial bit stream. Both the bit clock and the word-select clock come from an external master. The block samples them with its own fast system clock and never drives either one. Each word-select period carries the left word and then the right word, most significant bit first. A static format input selects one of two framings. In the left-justified framing the first data bit lines up with the word-select edge. In the I2S framing the first data bit comes one bit-clock period later, and the word-select polarity that marks the left channel is inverted.

The host presents a pair on the parallel inputs and pulses the load strobe. The pair is held in a pending register. The block moves it into the transmit register at the start of the next left-channel half-frame. The pair being sent therefore never changes part way through a frame.

The system clock must run at least eight times faster than the bit clock. The master changes word-select on a falling bit-clock edge. Each half-frame must be at least 16 bit periods long for left-justified framing and at least 17 for I2S framing.

Top module: `aud_slave_tx`

## Requirements
- R1: With `fmt_i2s_i` = 0 (left-justified), the MSB of a channel word is launched on the same falling bit-clock edge at which word-select changes. The remaining 15 bits follow MSB first, one per falling edge.
- R2: With `fmt_i2s_i` = 1 (I2S), the MSB is launched on the second falling bit-clock edge of the half-frame, one bit period later than in R1. The other 15 bits follow MSB first, and the first slot of the half-frame is driven 0.
- R3: In left-justified framing, word-select high selects the left word and low selects the right word. In I2S framing, word-select low selects the left word and high selects the right word.
- R4: `sdata_o` changes only in response to a falling bit-clock edge. It holds its value for the whole high phase of the bit clock. The word-select level used for half-frame tracking is captured on rising bit-clock edges.
- R5: Every bit slot in a half-frame after the 16 data slots is driven 0.
- R6: A pair loaded with `load_i` is sent starting at the next left half-frame. A load during a frame does not change either word of that frame, and the new pair appears in the following frame.
- R7: While reset is high, `sdata_o` is 0. After reset, `sdata_o` stays 0 until a word-select transition has started a half-frame, and the transmit pair resets to zero.
- R8: Sample words pass bit-exact as two's complement, including the most negative (0x8000) and most positive (0x7FFF) values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both external clocks |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Bit clock from the external master |
| lrck_i | input | 1 | Word-select clock from the external master |
| fmt_i2s_i | input | 1 | Framing select: 0 left-justified, 1 I2S |
| load_i | input | 1 | One-cycle strobe that captures the parallel pair |
| left_i | input | 16 | Left-channel sample, two's complement |
| right_i | input | 16 | Right-channel sample, two's complement |
| sdata_o | output | 1 | Serial data output |

## Verification
The vector patterns combine both framings with half-frame lengths of 16, 17, 20, 24 and 32 bit periods. The shortest lengths show whether the first data slot is placed correctly and whether the LSB is still sent at the edge of the window. The longer lengths show whether the slots after the data are forced low. The sample values include alternating bits, single set bits at either end, all ones, and the two extreme two's complement values. These tell apart a reversed bit order, an off-by-one slot offset and swapped channels. Directed runs cover the following cases:
- a load in the middle of a frame, which separates latching at the left half-frame from immediate update;
- a bit clock that runs with no word-select edge after reset;
- a reset asserted in the middle of a frame.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    localparam int unsigned SAMPLE_W = 16;

    typedef enum logic {
        FMT_LEFTJ = 1'b0,
        FMT_I2S   = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_pair_t;

    // Word-select level that marks the left half-frame for a framing.
    function automatic logic is_left_level(input logic lvl, input frame_fmt_e fmt);
        return (fmt == FMT_LEFTJ) ? lvl : ~lvl;
    endfunction

    // Bit sent in a given slot of a half-frame; slots outside the window are 0.
    function automatic logic slot_bit(input logic [SAMPLE_W-1:0] word,
                                      input frame_fmt_e          fmt,
                                      input logic [7:0]          slot);
        int first;
        int pos;
        first = (fmt == FMT_I2S) ? 1 : 0;
        pos   = int'(slot) - first;
        if (pos >= 0 && pos < int'(SAMPLE_W))
            return word[int'(SAMPLE_W) - 1 - pos];
        return 1'b0;
    endfunction

endpackage

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_i,
    input  logic lrck_i,
    output logic bck_rise_o,
    output logic bck_fall_o,
    output logic lrck_lvl_o
);
    // bit 0 carries the bit clock, bit 1 the word-select clock
    logic [1:0] chain [STAGES];
    logic       bck_d;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= {lrck_i, bck_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bck_d <= 1'b0;
        else     bck_d <= chain[STAGES-1][0];
    end

    assign bck_rise_o = chain[STAGES-1][0] & ~bck_d;
    assign bck_fall_o = ~chain[STAGES-1][0] & bck_d;
    assign lrck_lvl_o = chain[STAGES-1][1];

endmodule

// File: rtl/aud_slot_track.sv
module aud_slot_track
    import aud_fmt_pkg::*;
#(
    parameter int unsigned SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bck_rise,
    input  logic              bck_fall,
    input  logic              lrck_lvl,
    input  frame_fmt_e        fmt,
    output logic [SLOT_W-1:0] slot_nxt_o,
    output logic              chan_left_nxt_o,
    output logic              left_start_o,
    output logic [SLOT_W-1:0] slot_q_o,
    output logic              lr_q_o
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

    logic              lr_q;
    logic [SLOT_W-1:0] slot_q;
    logic              chan_left_q;
    logic              changed;

    assign changed = (lrck_lvl != lr_q);

    always_comb begin
        if (changed)               slot_nxt_o = '0;
        else if (slot_q == SLOT_MAX) slot_nxt_o = SLOT_MAX;
        else                       slot_nxt_o = slot_q + 1'b1;
        chan_left_nxt_o = changed ? is_left_level(lrck_lvl, fmt) : chan_left_q;
    end

    assign left_start_o = bck_fall & changed & is_left_level(lrck_lvl, fmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q        <= 1'b0;
            slot_q      <= SLOT_MAX;
            chan_left_q <= 1'b0;
        end else begin
            if (bck_rise) lr_q <= lrck_lvl;
            if (bck_fall) begin
                slot_q      <= slot_nxt_o;
                chan_left_q <= chan_left_nxt_o;
            end
        end
    end

    assign slot_q_o = slot_q;
    assign lr_q_o   = lr_q;

endmodule

// File: rtl/aud_pair_hold.sv
module aud_pair_hold
    import aud_fmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  stereo_pair_t pair_i,
    input  logic         left_start,
    output stereo_pair_t pair_nxt_o,
    output stereo_pair_t active_o
);
    stereo_pair_t pending_q;
    stereo_pair_t active_q;

    assign pair_nxt_o = left_start ? pending_q : active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            if (load_i)     pending_q <= pair_i;
            if (left_start) active_q  <= pending_q;
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/aud_slave_tx.sv
module aud_slave_tx
    import aud_fmt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SLOT_W      = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bck_i,
    input  logic                lrck_i,
    input  logic                fmt_i2s_i,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sdata_o
);
    localparam int unsigned MIN_SLOT_W = $clog2(SAMPLE_W + 2);

    if (SLOT_W < MIN_SLOT_W || SLOT_W > 8) begin : g_bad_slot_w
        initial $error("SLOT_W out of range");
    end

    frame_fmt_e        fmt;
    logic              bck_rise;
    logic              bck_fall;
    logic              lrck_lvl;
    logic [SLOT_W-1:0] slot_nxt;
    logic              chan_left_nxt;
    logic              left_start;
    logic [SLOT_W-1:0] slot_q;
    logic              lr_q;
    stereo_pair_t      pair_in;
    stereo_pair_t      pair_nxt;
    stereo_pair_t      active;
    logic [SAMPLE_W-1:0] word_sel;
    logic              sdata_q;

    assign fmt     = frame_fmt_e'(fmt_i2s_i);
    assign pair_in = '{left: left_i, right: right_i};

    aud_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .bck_i      (bck_i),
        .lrck_i     (lrck_i),
        .bck_rise_o (bck_rise),
        .bck_fall_o (bck_fall),
        .lrck_lvl_o (lrck_lvl)
    );

    aud_slot_track #(.SLOT_W(SLOT_W)) u_track (
        .clk             (clk),
        .rst             (rst),
        .bck_rise        (bck_rise),
        .bck_fall        (bck_fall),
        .lrck_lvl        (lrck_lvl),
        .fmt             (fmt),
        .slot_nxt_o      (slot_nxt),
        .chan_left_nxt_o (chan_left_nxt),
        .left_start_o    (left_start),
        .slot_q_o        (slot_q),
        .lr_q_o          (lr_q)
    );

    aud_pair_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .pair_i     (pair_in),
        .left_start (left_start),
        .pair_nxt_o (pair_nxt),
        .active_o   (active)
    );

    assign word_sel = chan_left_nxt ? pair_nxt.left : pair_nxt.right;

    always_ff @(posedge clk) begin
        if (rst)           sdata_q <= 1'b0;
        else if (bck_fall) sdata_q <= slot_bit(word_sel, fmt, 8'(slot_nxt));
    end

    assign sdata_o = sdata_q;

endmodule

// File: rtl/aud_slave_tx_chk.sv
module aud_slave_tx_chk
    import aud_fmt_pkg::*;
#(
    parameter int unsigned SLOT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bck_rise,
    input logic              bck_fall,
    input logic              lrck_lvl,
    input logic              lr_q,
    input logic [SLOT_W-1:0] slot_q,
    input logic              left_start,
    input stereo_pair_t      active,
    input logic              sdata_o
);
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> $past(bck_fall)); // R4

    AST_LRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(lr_q) |-> $past(bck_rise)); // R4

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bck_rise && bck_fall)); // R4

    AST_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
        (slot_q > SLOT_W'(SAMPLE_W)) |-> !sdata_o); // R5

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> $past(left_start)); // R6

    AST_HALF_RESTART: assert property (@(posedge clk) disable iff (rst)
        ($past(bck_fall) && ($past(lrck_lvl) != $past(lr_q))) |-> (slot_q == '0)); // R1

endmodule

bind aud_slave_tx aud_slave_tx_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bck_rise   (bck_rise),
    .bck_fall   (bck_fall),
    .lrck_lvl   (lrck_lvl),
    .lr_q       (lr_q),
    .slot_q     (slot_q),
    .left_start (left_start),
    .active     (active),
    .sdata_o    (sdata_o)
);

// File: tb/aud_slave_tx_tb_top.sv
module aud_slave_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b1;
    logic        lrck = 1'b0;
    logic        fmt = 1'b0;
    logic        load = 1'b0;
    logic [15:0] left_w = '0;
    logic [15:0] right_w = '0;
    logic        dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    aud_slave_tx dut_i (
        .clk       (clk),
        .rst       (rst),
        .bck_i     (bck),
        .lrck_i    (lrck),
        .fmt_i2s_i (fmt),
        .load_i    (load),
        .left_i    (left_w),
        .right_i   (right_w),
        .sdata_o   (dout)
    );

    localparam int VEC_N = 6;
    // {format, left word, right word}
    localparam logic [32:0] VEC_DATA [VEC_N] = '{
        {1'b0, 16'h8001, 16'h7FFE},
        {1'b0, 16'hA5C3, 16'h0000},
        {1'b1, 16'hFFFF, 16'h1234},
        {1'b1, 16'h8000, 16'h0001},
        {1'b0, 16'h0F0F, 16'hF0F0},
        {1'b1, 16'h7FFF, 16'hC3A5}
    };
    localparam int VEC_HALF [VEC_N] = '{32, 24, 32, 17, 16, 20};

    function automatic logic exp_bit(input logic [15:0] w, input logic f, input int k);
        int first;
        first = f ? 1 : 0;
        if (k >= first && k < first + 16) return w[15 - (k - first)];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic load_pair(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        left_w  = l;
        right_w = r;
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
    endtask

    // One bit period: fall (with word-select level), sample late in the low
    // phase, then rise and re-sample at the end of the high phase.
    task automatic bit_slot(input logic lvl, input bit chk, input logic exp, input string tag);
        @(negedge clk);
        bck  = 1'b0;
        lrck = lvl;
        repeat (7) @(negedge clk);
        if (chk) check(tag, dout, exp);
        @(negedge clk);
        bck = 1'b1;
        repeat (7) @(negedge clk);
        if (chk) check({tag, " R4 hold"}, dout, exp);
    endtask

    task automatic half(input logic lvl, input logic f, input logic [15:0] w, input int len,
                        input bit chk, input string tag,
                        input bit mid, input logic [15:0] ml, input logic [15:0] mr);
        for (int k = 0; k < len; k++) begin
            bit_slot(lvl, chk, exp_bit(w, f, k), tag);
            if (mid && k == 3) load_pair(ml, mr);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R7: reset state
        repeat (5) @(negedge clk);
        check("R7 reset output", dout, 1'b0);
        rst = 1'b0;

        // R7: bit clock runs but word-select never moves -> output stays low
        load_pair(16'hFFFF, 16'hFFFF);
        for (int k = 0; k < 20; k++) bit_slot(1'b0, 1'b1, 1'b0, "R7 no frame yet");

        // Vector table: R1 R2 R3 R5 R8
        for (int v = 0; v < VEC_N; v++) begin
            logic f;
            logic [15:0] l, r;
            logic lvl_l;
            {f, l, r} = VEC_DATA[v];
            fmt   = f;
            lvl_l = f ? 1'b0 : 1'b1;
            load_pair(l, r);
            half(~lvl_l, f, 16'h0, VEC_HALF[v], 1'b0, "", 1'b0, 16'h0, 16'h0);
            half(lvl_l, f, l, VEC_HALF[v], 1'b1,
                 f ? "R2 R3 R5 R8 left" : "R1 R3 R5 R8 left", 1'b0, 16'h0, 16'h0);
            half(~lvl_l, f, r, VEC_HALF[v], 1'b1,
                 f ? "R2 R3 R5 R8 right" : "R1 R3 R5 R8 right", 1'b0, 16'h0, 16'h0);
        end

        // R6: load in the middle of a frame only shows up in the next frame
        fmt = 1'b0;
        load_pair(16'h1111, 16'h2222);
        half(1'b0, 1'b0, 16'h0, 32, 1'b0, "", 1'b0, 16'h0, 16'h0);
        half(1'b1, 1'b0, 16'h1111, 32, 1'b1, "R6 old left", 1'b1, 16'hAAAA, 16'h5555);
        half(1'b0, 1'b0, 16'h2222, 32, 1'b1, "R6 old right", 1'b0, 16'h0, 16'h0);
        half(1'b1, 1'b0, 16'hAAAA, 32, 1'b1, "R6 new left", 1'b0, 16'h0, 16'h0);
        half(1'b0, 1'b0, 16'h5555, 32, 1'b1, "R6 new right", 1'b0, 16'h0, 16'h0);

        // R7: reset in the middle of a frame clears output and the pair
        load_pair(16'hFFFF, 16'hFFFF);
        half(1'b1, 1'b0, 16'hFFFF, 8, 1'b1, "R1 pre-reset", 1'b0, 16'h0, 16'h0);
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 mid-frame reset", dout, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 24; k++) bit_slot(1'b1, 1'b1, 1'b0, "R7 after reset");
        for (int k = 0; k < 24; k++) bit_slot(1'b0, 1'b1, 1'b0, "R7 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule